// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer by another over several clock cycles, one quotient bit per cycle. A single remainder register of twice the operand width shifts left on every step. Its upper half is compared against the divisor with one operand-width subtractor, and its lower half collects the quotient bits as they are produced. A start strobe launches an operation. A select input chooses between unsigned and two's-complement division.

For signed division, the operands are first replaced by their magnitudes. The unsigned iteration then runs on those magnitudes. One last cycle applies the signs: the quotient is negated when the operand signs differ, and the remainder follows the sign of the dividend. A zero divisor skips the iteration entirely and raises a flag.

When an operation finishes, the block raises a one-cycle completion pulse. The quotient and remainder outputs keep their values until the next operation completes.

Top module: `seq_divider`

## Requirements
- R1: In unsigned mode with a non-zero divisor, the results satisfy dividend = quotient × divisor + remainder, with remainder < divisor.
- R2: For a non-zero divisor, `done_o` rises WIDTH+1 clock edges after the edge that accepts `start_i`, and stays high for exactly one cycle. Between completions, `quotient_o` and `remainder_o` hold their values.
- R3: In signed mode (`signed_i`=1), the quotient is the truncated quotient of the magnitudes. It is negated when the dividend MSB and the divisor MSB differ.
- R4: In signed mode, a non-zero remainder has the same sign bit as the dividend. Its magnitude is the remainder of the magnitudes.
- R5: A zero divisor completes on the edge after acceptance, with `div_zero_o`=1, the quotient all ones and the remainder equal to the dividend.
- R6: A `start_i` pulse during an operation in progress is ignored. Neither that operation's result nor its completion time changes.
- R7: After reset, `done_o`, `div_zero_o`, `quotient_o` and `remainder_o` are all zero.
- R8: In signed mode, the most negative value divided by -1 gives the most negative value as the quotient pattern, with remainder 0.
- R9: Dividing 74 (1001010b) by 8 (1000b) gives quotient 9 (1001b) and remainder 2 (10b).
- R10: A completion with a non-zero divisor clears `div_zero_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch strobe, taken only when idle |
| signed_i | input | 1 | 1 selects two's-complement division |
| dividend_i | input | WIDTH | Dividend, sampled at acceptance |
| divisor_i | input | WIDTH | Divisor, sampled at acceptance |
| quotient_o | output | WIDTH | Quotient (low half of the result) |
| remainder_o | output | WIDTH | Remainder (high half of the result) |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last completed operation had a zero divisor |

## Verification
The assertions take for granted that the operands and the mode are sampled only in the cycle where `start_i` meets an idle block. The checker keeps its own copy of the operands captured in that cycle and does not track the live inputs. The bench holds `start_i` high for a single cycle and changes the operands only around that pulse. When it raises `start_i` mid-operation, it uses deliberately different operands, so that the result shows whether the second pulse was sampled.

The sweep runs an 8-bit configuration. Every dividend is paired with a set of divisors that covers zero, one, the powers of two, the all-ones pattern and the most negative value, in both modes.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_cond_neg.sv
module div_cond_neg #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             neg_i,
  output logic [WIDTH-1:0] val_o
);
  always_comb val_o = neg_i ? (~val_i + WIDTH'(1)) : val_i;
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] rem_hi_i,
  input  logic [WIDTH-1:0] rem_lo_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] rem_hi_o,
  output logic [WIDTH-1:0] rem_lo_o
);
  // shift first, keep the bit shifted out of the upper half
  logic [WIDTH:0] shifted;
  logic [WIDTH:0] trial;
  logic           fits;

  always_comb begin
    shifted  = {rem_hi_i, rem_lo_i[WIDTH-1]};
    trial    = shifted - {1'b0, divisor_i};
    fits     = ~trial[WIDTH];
    // negative trial: restore the shifted value
    rem_hi_o = fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
    rem_lo_o = {rem_lo_i[WIDTH-2:0], fits};
  end
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             signed_i,
  input logic [WIDTH-1:0] dividend_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic [WIDTH-1:0] quotient_o,
  input logic [WIDTH-1:0] remainder_o,
  input logic             done_o,
  input logic             div_zero_o,
  input logic             busy_i
);
  localparam int CYW = $clog2(WIDTH + 3);
  localparam logic [CYW-1:0] CYMAX = CYW'(WIDTH + 2);

  logic [WIDTH-1:0]   op_a_q, op_b_q;
  logic               op_signed_q;
  logic [CYW-1:0]     cyc_q;
  logic [2*WIDTH-1:0] recon;
  logic               accept;

  assign accept = start_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_a_q      <= '0;
      op_b_q      <= '0;
      op_signed_q <= 1'b0;
      cyc_q       <= CYMAX;
    end else if (accept) begin
      op_a_q      <= dividend_i;
      op_b_q      <= divisor_i;
      op_signed_q <= signed_i;
      cyc_q       <= '0;
    end else if (cyc_q < CYMAX) begin
      cyc_q <= cyc_q + CYW'(1);
    end
  end

  always_comb recon = (2*WIDTH)'(quotient_o) * (2*WIDTH)'(op_b_q) + (2*WIDTH)'(remainder_o);

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o) |-> (cyc_q == CYW'(WIDTH + 1)));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(quotient_o) && $stable(remainder_o)));

  assert_zero_div_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && divisor_i == '0) |=> (done_o && div_zero_o && quotient_o == '1
                                      && remainder_o == $past(dividend_i)));

  assert_unsigned_identity_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o && !op_signed_q) |->
      (recon == (2*WIDTH)'(op_a_q) && remainder_o < op_b_q));

  assert_rem_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o && op_signed_q && remainder_o != '0) |->
      (remainder_o[WIDTH-1] == op_a_q[WIDTH-1]));

  assert_busy_no_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cyc_q < CYW'(WIDTH)) |=> !done_o);
endmodule

bind seq_divider div_checker #(.WIDTH(WIDTH)) u_div_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .signed_i   (signed_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .quotient_o (quotient_o),
  .remainder_o(remainder_o),
  .done_o     (done_o),
  .div_zero_o (div_zero_o),
  .busy_i     (busy)
);

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             signed_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o,
  output logic             done_o,
  output logic             div_zero_o
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  div_state_e       state_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] divisor_q, rem_hi_q, rem_lo_q;
  logic             q_neg_q, r_neg_q;
  logic             busy, accept;

  logic             a_neg, b_neg;
  logic [WIDTH-1:0] mag_a, mag_b;
  logic [WIDTH-1:0] step_hi, step_lo;
  logic [WIDTH-1:0] q_fixed, r_fixed;

  assign busy   = (state_q != ST_IDLE);
  assign accept = start_i && !busy;
  assign a_neg  = signed_i && dividend_i[WIDTH-1];
  assign b_neg  = signed_i && divisor_i[WIDTH-1];

  div_cond_neg #(.WIDTH(WIDTH)) u_mag_a (.val_i(dividend_i), .neg_i(a_neg), .val_o(mag_a));
  div_cond_neg #(.WIDTH(WIDTH)) u_mag_b (.val_i(divisor_i),  .neg_i(b_neg), .val_o(mag_b));

  div_step #(.WIDTH(WIDTH)) u_step (
    .rem_hi_i (rem_hi_q),
    .rem_lo_i (rem_lo_q),
    .divisor_i(divisor_q),
    .rem_hi_o (step_hi),
    .rem_lo_o (step_lo)
  );

  div_cond_neg #(.WIDTH(WIDTH)) u_fix_q (.val_i(rem_lo_q), .neg_i(q_neg_q), .val_o(q_fixed));
  div_cond_neg #(.WIDTH(WIDTH)) u_fix_r (.val_i(rem_hi_q), .neg_i(r_neg_q), .val_o(r_fixed));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      divisor_q   <= '0;
      rem_hi_q    <= '0;
      rem_lo_q    <= '0;
      q_neg_q     <= 1'b0;
      r_neg_q     <= 1'b0;
      quotient_o  <= '0;
      remainder_o <= '0;
      done_o      <= 1'b0;
      div_zero_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (divisor_i == '0) begin
              quotient_o  <= '1;
              remainder_o <= dividend_i;
              div_zero_o  <= 1'b1;
              done_o      <= 1'b1;
            end else begin
              divisor_q <= mag_b;
              rem_hi_q  <= '0;
              rem_lo_q  <= mag_a;
              q_neg_q   <= a_neg ^ b_neg;
              r_neg_q   <= a_neg;
              cnt_q     <= '0;
              state_q   <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          rem_hi_q <= step_hi;
          rem_lo_q <= step_lo;
          cnt_q    <= cnt_q + CW'(1);
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX: begin
          quotient_o  <= q_fixed;
          remainder_o <= r_fixed;
          div_zero_o  <= 1'b0;
          done_o      <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: tb/tb_seq_divider.sv
`timescale 1ns/1ps
module tb_seq_divider;
  localparam int W = 8;
  localparam int LAT = W + 2;  // negedges from drive to done visible

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         signed_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic [W-1:0] quotient_o, remainder_o;
  logic         done_o, div_zero_o;

  int tests = 0;
  int fails = 0;

  always #4 clk_i = ~clk_i;

  seq_divider #(.WIDTH(W)) dut (
    .clk_i, .rst_ni, .start_i, .signed_i, .dividend_i, .divisor_i,
    .quotient_o, .remainder_o, .done_o, .div_zero_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                                output logic [W-1:0] q, output logic [W-1:0] r,
                                output bit dz);
    logic [W-1:0] ma, mb;
    if (b == '0) begin
      q = '1; r = a; dz = 1'b1;
    end else begin
      dz = 1'b0;
      ma = (s && a[W-1]) ? W'(-a) : a;
      mb = (s && b[W-1]) ? W'(-b) : b;
      q = ma / mb;
      r = ma % mb;
      if (s && (a[W-1] ^ b[W-1])) q = W'(-q);
      if (s && a[W-1]) r = W'(-r);
    end
  endfunction

  // Drive one op, wait for done, return number of negedges waited.
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                        input bit poke, output int n);
    @(negedge clk_i);
    start_i = 1'b1; dividend_i = a; divisor_i = b; signed_i = s;
    n = 0;
    for (int k = 0; k < 4 * LAT; k++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      n++;
      if (poke && n == 3) begin
        start_i = 1'b1; dividend_i = ~a; divisor_i = 8'h03; signed_i = ~s;
      end
      if (done_o) break;
    end
    start_i = 1'b0;
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                        input string req);
    int n;
    logic [W-1:0] eq, er;
    bit edz;
    model(a, b, s, eq, er, edz);
    launch(a, b, s, 1'b0, n);
    chk(n == (edz ? 1 : LAT), {req, " R2 latency"}, n, edz ? 1 : LAT);
    chk(quotient_o == eq && remainder_o == er && div_zero_o == edz, req,
        {quotient_o, remainder_o, 7'b0, div_zero_o}, {eq, er, 7'b0, edz});
  endtask

  initial begin
    #(8ns * 190000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] hq, hr;
    int n;
    logic [W-1:0] dv [16] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h07, 8'h08, 8'h10,
                              8'h40, 8'h55, 8'h7f, 8'h80, 8'h81, 8'haa, 8'hfe, 8'hff};
    repeat (3) @(negedge clk_i);
    chk(done_o == 0 && div_zero_o == 0 && quotient_o == 0 && remainder_o == 0,
        "R7 reset", {done_o, div_zero_o, quotient_o, remainder_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_op(8'd74, 8'd8, 1'b0, "R9");
    chk(quotient_o == 8'd9 && remainder_o == 8'd2, "R9 literal", {quotient_o, remainder_o}, 16'h0902);

    // R2: done for one cycle, outputs hold afterwards
    hq = quotient_o; hr = remainder_o;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R2 pulse", done_o, 0);
    repeat (3) @(negedge clk_i);
    chk(quotient_o == hq && remainder_o == hr, "R2 hold", {quotient_o, remainder_o}, {hq, hr});

    run_op(8'h80, 8'hff, 1'b1, "R8");
    chk(quotient_o == 8'h80 && remainder_o == 8'h00, "R8 literal", {quotient_o, remainder_o}, 16'h8000);

    run_op(8'h37, 8'h00, 1'b0, "R5");
    run_op(8'h37, 8'h05, 1'b0, "R10");
    chk(div_zero_o == 1'b0, "R10 flag cleared", div_zero_o, 0);

    // R6: second start mid-run is ignored
    launch(8'd200, 8'd7, 1'b0, 1'b1, n);
    chk(n == LAT, "R6 latency", n, LAT);
    chk(quotient_o == 8'd28 && remainder_o == 8'd4, "R6 result", {quotient_o, remainder_o}, 16'h1c04);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R6 no extra done", done_o, 0);

    run_op(8'hf9, 8'h02, 1'b1, "R3 R4 -7/2");
    chk(quotient_o == 8'hfd && remainder_o == 8'hff, "R3 R4 -7/2 literal",
        {quotient_o, remainder_o}, 16'hfdff);

    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 16; j++)
          run_op(W'(a), dv[j], m[0], m[0] ? "R3 R4 R5 sweep" : "R1 R5 sweep");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule